// File: doc/BRIEF.md
# Single-Transaction I2C Command Master

This block runs one complete I2C master transaction from a single 24-bit command word. The word is split into three byte lanes: lane 0 in bits 23:16, lane 1 in bits 15:8 and lane 2 in bits 7:0. Lanes go onto the bus in that order, MSB first. Lane 0 carries the 7-bit slave address, and its bit 0 (word bit 16) picks the direction. A write sends two or three lanes, as set by a length input. A read sends only lane 0, then takes one byte from the slave, answers it with a NACK, and writes the received byte into lane 2 of the result word.

A transfer is launched by a one-cycle start pulse. It runs to STOP even if an acknowledge is missing. At the end the block gives a one-cycle interrupt and a status bit that is 1 only when every acknowledge the master expected was present. A programmable divider sets the bus speed. Both lines are open drain: each output only asks for its line to be pulled low. A bypass input disconnects the sequencer and lets two software bits drive the lines directly.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both lines are released (`scl_oe` = 0, `sda_oe` = 0), and `busy`, `irq`, `ack_ok` and `data_q` are all 0.
- R2: A write (word bit 16 = 0) with `three_byte` = 0 puts exactly two bytes on the bus, bits 23:16 and then bits 15:8, each MSB first.
- R3: A write with `three_byte` = 1 puts three bytes on the bus, bits 23:16, 15:8 and 7:0, in that order.
- R4: A read (word bit 16 = 1) sends only bits 23:16, then receives one byte and leaves SDA released in that byte's acknowledge slot, which is a NACK. At completion `data_q` equals the command word with bits 7:0 replaced by the received byte.
- R5: Every transfer shows exactly one START (SDA falls while SCL is high) and one STOP (SDA rises while SCL is high). At no other time does the master change SDA while SCL is high.
- R6: `busy` rises the cycle after an accepted start and stays high until STOP is complete. `irq` is high for exactly one cycle, the cycle in which `busy` first reads low again.
- R7: `ack_ok` at completion is 1 only if the slave acknowledged every byte the master sent. A missing acknowledge does not shorten the transfer.
- R8: A start pulse while `busy` is high is ignored. The running transfer, its bytes and its result word are unchanged.
- R9: While `sw_mode` = 1, `scl_oe` = !`sw_scl` and `sda_oe` = !`sw_sda`, and a start pulse does not launch a transfer.
- R10: One SCL period lasts 4*(`div_cfg`+1) clock cycles.
- R11: The acknowledge bit and the read data bits are sampled while SCL is released (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cfg | input | DIV_W | Quarter-period length of SCL minus one, in clock cycles |
| cmd_word | input | 24 | Command word, captured when a start is accepted |
| three_byte | input | 1 | 1: a write sends three bytes; 0: it sends two |
| start | input | 1 | Launch pulse |
| sw_mode | input | 1 | 1: lines are driven by `sw_scl`/`sw_sda` |
| sw_scl | input | 1 | Software SCL level in bypass mode |
| sw_sda | input | 1 | Software SDA level in bypass mode |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion pulse |
| ack_ok | output | 1 | All expected acknowledges were seen |
| data_q | output | 24 | Result word (command word, with the read byte in bits 7:0) |

## Verification
The hardest case to reach from the ports is a transfer that loses an acknowledge and still finishes every byte. For a read, a missing acknowledge on the address must still be followed by the slave's byte and the master NACK. The bench's slave model takes a per-byte mask that makes it withhold its acknowledge on chosen bytes. One case sets the mask bit of a third byte that a two-byte write never sends, and in that case the status must stay good. A second start pulse is fired in the middle of a transfer to show it is ignored.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 3;
  localparam int WORD_W = LANE_W * LANES;
  localparam int DIR_BIT = WORD_W - LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_TX, ST_ACK, ST_RX, ST_NACK, ST_STOP
  } seq_state_t;

  // number of bytes the master puts on the wire
  function automatic logic [1:0] tx_bytes(input logic rd, input logic three);
    if (rd) return 2'd1;
    return three ? 2'd3 : 2'd2;
  endfunction

  // place the received byte in the lowest lane
  function automatic logic [WORD_W-1:0] merge_rx(input logic [WORD_W-1:0] word,
                                                 input logic [LANE_W-1:0] rx);
    return {word[WORD_W-1:LANE_W], rx};
  endfunction
endpackage

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_cfg);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              tick,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              three_byte,
  input  logic              sda_in,
  output seq_state_t        state,
  output logic [1:0]        ph,
  output logic              drv_bit,
  output logic              busy,
  output logic              irq,
  output logic              ack_ok,
  output logic [WORD_W-1:0] data_q,
  output logic              sample_evt
);
  logic [WORD_W-1:0] sh;
  logic [LANE_W-1:0] rx;
  logic [2:0]        bit_idx;
  logic [1:0]        byte_idx;
  logic [1:0]        nbytes;
  logic              rd;

  assign busy       = (state != ST_IDLE);
  assign sample_evt = tick && (ph == 2'd2) && (state == ST_ACK || state == ST_RX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ph       <= 2'd0;
      sh       <= '0;
      rx       <= '0;
      bit_idx  <= 3'd7;
      byte_idx <= 2'd0;
      nbytes   <= 2'd0;
      rd       <= 1'b0;
      drv_bit  <= 1'b1;
      ack_ok   <= 1'b0;
      irq      <= 1'b0;
      data_q   <= '0;
    end else begin
      irq <= 1'b0;
      if (state == ST_IDLE) begin
        if (go) begin
          state    <= ST_START;
          ph       <= 2'd0;
          sh       <= cmd_word;
          data_q   <= cmd_word;
          rd       <= cmd_word[DIR_BIT];
          nbytes   <= tx_bytes(cmd_word[DIR_BIT], three_byte);
          byte_idx <= 2'd0;
          bit_idx  <= 3'd7;
          ack_ok   <= 1'b1;
          drv_bit  <= 1'b0;
        end
      end else if (tick) begin
        ph <= ph + 2'd1;
        // new SDA value is set only on entry to quarter 1 (SCL low)
        if (ph == 2'd0) begin
          case (state)
            ST_TX:                   drv_bit <= sh[WORD_W-1];
            ST_ACK, ST_RX, ST_NACK:  drv_bit <= 1'b1;
            default:                 drv_bit <= drv_bit;
          endcase
        end
        if (sample_evt) begin
          if (state == ST_ACK && sda_in) ack_ok <= 1'b0;
          if (state == ST_RX)            rx <= {rx[LANE_W-2:0], sda_in};
        end
        if (ph == 2'd3) begin
          case (state)
            ST_START: state <= ST_TX;
            ST_TX: begin
              sh <= {sh[WORD_W-2:0], 1'b0};
              if (bit_idx == 3'd0) state <= ST_ACK;
              else                 bit_idx <= bit_idx - 3'd1;
            end
            ST_ACK: begin
              bit_idx  <= 3'd7;
              byte_idx <= byte_idx + 2'd1;
              if (rd)                               state <= ST_RX;
              else if (byte_idx + 2'd1 == nbytes)   state <= ST_STOP;
              else                                  state <= ST_TX;
            end
            ST_RX: begin
              if (bit_idx == 3'd0) state <= ST_NACK;
              else                 bit_idx <= bit_idx - 3'd1;
            end
            ST_NACK: state <= ST_STOP;
            ST_STOP: begin
              state <= ST_IDLE;
              irq   <= 1'b1;
              if (rd) data_q <= merge_rx(data_q, rx);
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_od_pins.sv
module i2c_od_pins
  import i2c_cmd_pkg::*;
(
  input  seq_state_t state,
  input  logic [1:0] ph,
  input  logic       drv_bit,
  input  logic       sw_mode,
  input  logic       sw_scl,
  input  logic       sw_sda,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic scl_rel;
  logic sda_rel;

  always_comb begin
    case (state)
      ST_IDLE: begin
        scl_rel = 1'b1;
        sda_rel = 1'b1;
      end
      ST_START: begin
        scl_rel = (ph != 2'd3);
        sda_rel = (ph == 2'd0);
      end
      ST_STOP: begin
        scl_rel = ph[1];
        sda_rel = (ph == 2'd3) || (ph == 2'd0 && drv_bit);
      end
      default: begin
        scl_rel = ph[1];
        sda_rel = drv_bit;
      end
    endcase
  end

  assign scl_oe = sw_mode ? !sw_scl : !scl_rel;
  assign sda_oe = sw_mode ? !sw_sda : !sda_rel;
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              three_byte,
  input  logic              start,
  input  logic              sw_mode,
  input  logic              sw_scl,
  input  logic              sw_sda,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              irq,
  output logic              ack_ok,
  output logic [WORD_W-1:0] data_q
);
  seq_state_t state;
  logic [1:0] ph;
  logic       drv_bit;
  logic       tick;
  logic       go;
  logic       sample_evt;
  logic       in_start;
  logic       in_stop;

  assign go       = start && !busy && !sw_mode;
  assign in_start = (state == ST_START);
  assign in_stop  = (state == ST_STOP);

  i2c_qtr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_cfg(div_cfg), .tick(tick)
  );

  i2c_byte_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
    .cmd_word(cmd_word), .three_byte(three_byte), .sda_in(sda_in),
    .state(state), .ph(ph), .drv_bit(drv_bit), .busy(busy), .irq(irq),
    .ack_ok(ack_ok), .data_q(data_q), .sample_evt(sample_evt)
  );

  i2c_od_pins u_pins (
    .state(state), .ph(ph), .drv_bit(drv_bit), .sw_mode(sw_mode),
    .sw_scl(sw_scl), .sw_sda(sw_sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_mode,
  input logic        start,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        busy,
  input logic        irq,
  input logic [23:0] data_q,
  input logic        in_start,
  input logic        in_stop,
  input logic        sample_evt
);
  // R5: SDA pulled low under a high SCL only as START
  a_r5_fall_only_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_mode && $past(!sw_mode) && !scl_oe && $past(!scl_oe) && sda_oe && $past(!sda_oe))
    |-> in_start);

  // R5: SDA released under a high SCL only as STOP
  a_r5_rise_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_mode && $past(!sw_mode) && !scl_oe && $past(!scl_oe) && !sda_oe && $past(sda_oe))
    |-> in_stop);

  // R6: completion pulse lasts one cycle
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6: completion pulse marks the end of busy
  a_r6_irq_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));

  // R8: start during a transfer leaves the captured lanes alone
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(data_q[23:8]));

  // R11: sampling happens with SCL released
  a_r11_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !sw_mode) |-> !scl_oe);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .start(start),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .irq(irq), .data_q(data_q),
  .in_start(in_start), .in_stop(in_stop), .sample_evt(sample_evt)
);

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {cmd[23:0], three, nack_mask[2:0], read_value[7:0]}
  localparam logic [35:0] VECS [NVEC] = '{
    36'hA01234_0_00, 36'hA05678_8_00, 36'h429CE1_A_00,
    36'hA1FF00_0_5A, 36'h3B1234_1_C3, 36'h7E00FF_4_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div_cfg = 8'd1;
  logic [23:0] cmd_word = '0;
  logic three_byte = 1'b0, start = 1'b0;
  logic sw_mode = 1'b0, sw_scl = 1'b1, sw_sda = 1'b1;
  logic scl_oe, sda_oe, busy, irq, ack_ok;
  logic [23:0] data_q;
  logic slv_pull = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_pull);

  always #(CLK_PERIOD/2) clk = !clk;

  i2c_cmd_master dut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .cmd_word(cmd_word),
    .three_byte(three_byte), .start(start), .sw_mode(sw_mode), .sw_scl(sw_scl),
    .sw_sda(sw_sda), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .irq(irq), .ack_ok(ack_ok), .data_q(data_q)
  );

  // slave model and line monitor
  logic [2:0] nack_mask = '0;
  logic [7:0] rd_val = '0;
  int cyc = 0, s_bit = 0, s_byte = 0, n_start = 0, n_stop = 0;
  int r0 = 0, r1 = 0;
  logic [7:0] s_cur = '0;
  logic [7:0] s_seen [4];
  logic s_rd = 1'b0, m_ack_bit = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (scl_line && p_scl && p_sda && !sda_line) begin
      n_start++; s_bit = 0; s_byte = 0; s_rd = 1'b0;
    end
    if (scl_line && p_scl && !p_sda && sda_line) n_stop++;
    if (scl_line && !p_scl) begin
      r0 = r1; r1 = cyc;
      if (s_bit < 8) begin
        s_cur = {s_cur[6:0], sda_line};
        s_bit++;
      end else begin
        if (s_byte < 4) s_seen[s_byte] = s_cur;
        if (s_byte == 0) s_rd = s_cur[0];
        if (s_byte == 1 && s_rd) m_ack_bit = sda_line;
        s_byte++;
        s_bit = 0;
      end
    end
    if (!scl_line && p_scl) begin
      if (s_bit == 8 && (s_byte == 0 || !s_rd) && s_byte < 3)
        slv_pull = !nack_mask[s_byte];
      else if (s_rd && s_byte == 1 && s_bit < 8)
        slv_pull = !rd_val[7 - s_bit];
      else
        slv_pull = 1'b0;
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  int nchecks = 0, nerr = 0;
  logic done_flag = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_irq();
    int guard = 0;
    while (!irq && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk("R6 irq seen", {31'd0, irq}, 32'd1);
  endtask

  task automatic run_vec(input logic [35:0] v, input logic [7:0] dv, input logic late_start);
    logic rd;
    int ntx, nexp, st0, sp0;
    logic exp_ack;
    logic [23:0] exp_q;
    cmd_word = v[35:12]; three_byte = v[11]; nack_mask = v[10:8]; rd_val = v[7:0];
    div_cfg = dv;
    rd = v[28];
    ntx = rd ? 1 : (v[11] ? 3 : 2);
    nexp = rd ? 2 : ntx;
    exp_ack = 1'b1;
    for (int i = 0; i < ntx; i++) if (v[8+i]) exp_ack = 1'b0;
    exp_q = rd ? {v[35:20], v[7:0]} : v[35:12];
    st0 = n_start; sp0 = n_stop;
    pulse_start();
    chk("R6 busy after start", {31'd0, busy}, 32'd1);
    if (late_start) begin
      repeat (30) @(negedge clk);
      cmd_word = 24'h102030; three_byte = 1'b1;
      pulse_start();
      chk("R8 busy kept", {31'd0, busy}, 32'd1);
    end
    wait_irq();
    chk("R6 busy low at irq", {31'd0, busy}, 32'd0);
    chk("R7 R11 ack status", {31'd0, ack_ok}, {31'd0, exp_ack});
    chk("R2 R3 R4 R7 byte count", s_byte, nexp);
    chk("R2 R3 R4 first byte", {24'd0, s_seen[0]}, {24'd0, v[35:28]});
    if (!rd && ntx >= 2) chk("R2 R3 second byte", {24'd0, s_seen[1]}, {24'd0, v[27:20]});
    if (!rd && ntx == 3) chk("R3 third byte", {24'd0, s_seen[2]}, {24'd0, v[19:12]});
    if (rd) chk("R4 master nack", {31'd0, m_ack_bit}, 32'd1);
    chk(late_start ? "R8 result word" : "R4 result word", {8'd0, data_q}, {8'd0, exp_q});
    chk("R5 one start", n_start - st0, 1);
    chk("R5 one stop", n_stop - sp0, 1);
    chk("R10 scl period", r1 - r0, 4 * (dv + 1));
    @(negedge clk);
    chk("R6 irq one cycle", {31'd0, irq}, 32'd0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 scl_oe", {31'd0, scl_oe}, 32'd0);
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 busy irq ack", {29'd0, busy, irq, ack_ok}, 32'd0);
    chk("R1 data_q", {8'd0, data_q}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      run_vec(VECS[i], (i % 2 == 1) ? 8'd2 : 8'd1, 1'b0);

    // R8: second start in the middle of a transfer
    run_vec(36'hA01234_0_00, 8'd3, 1'b1);

    // R9: bypass mode
    @(negedge clk) begin sw_mode = 1'b1; sw_scl = 1'b0; sw_sda = 1'b1; end
    @(negedge clk);
    chk("R9 scl follows sw", {31'd0, scl_oe}, 32'd1);
    chk("R9 sda follows sw", {31'd0, sda_oe}, 32'd0);
    sw_scl = 1'b1; sw_sda = 1'b0;
    @(negedge clk);
    chk("R9 scl released", {31'd0, scl_oe}, 32'd0);
    chk("R9 sda pulled", {31'd0, sda_oe}, 32'd1);
    pulse_start();
    @(negedge clk);
    chk("R9 start ignored", {31'd0, busy}, 32'd0);
    sw_sda = 1'b1;
    @(negedge clk) sw_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 idle after bypass", {30'd0, scl_oe, sda_oe}, 32'd0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      nchecks++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
      $finish;
    end
  end
endmodule